// File: doc/BRIEF.md
# Quadrature Encoder Output Emulator

This block turns signed position-delta words into the A, B and index logic signals of an incremental encoder, so that a drive or controller can present a simulated shaft position to equipment that expects quadrature input. An internal update timer samples the 16-bit delta input once per update period and pulses an acknowledge output at that moment. Each sampled delta joins a signed backlog of edges still to be produced.

The backlog drains at no more than one quadrature edge per clock. Each edge moves a position accumulator one count up or down. The accumulator wraps at a programmable modulus. A second counter tracks the position within one revolution, which is four edges per programmed pulse. A, B and index are registered functions of these counters. The index is either a short marker or a level that is high for one half of each revolution.

A zero control clears the accumulator, the revolution counter and the backlog. An enable control gates all motion and all outputs.

Top module: `quad_enc_emu`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `enc_a`, `enc_b`, `enc_idx` and `delta_ack` are 0 and `pos_o` is 0.
- R2: While running, `delta_ack` pulses high for one clock every `cfg_period` clocks, or every clock when `cfg_period` is 0 or 1. `delta_in` is captured on the clock edge that ends an acknowledge cycle.
- R3: A captured positive delta N produces exactly N forward edges. The (A,B) sequence runs 00→10→11→01→00, and `pos_o` rises by N modulo the modulus. The phase is `pos_o` mod 4: 0→(0,0), 1→(1,0), 2→(1,1), 3→(0,1).
- R4: A captured negative delta −N produces exactly N reverse edges, and `pos_o` falls by N modulo the modulus.
- R5: At most one edge is produced per clock. `pos_o` changes by at most one count per clock, and A and B never change on the same clock while running.
- R6: A delta captured while earlier edges are still pending adds to the backlog. The net total of edges equals the sum of the deltas.
- R7: `pos_o` stays below `cfg_modulus`. Stepping up from `cfg_modulus`−1 gives 0, and stepping down from 0 gives `cfg_modulus`−1.
- R8: With `cfg_idx_half` = 0, `enc_idx` is high only when the revolution count (position mod 4·`cfg_ppr`) is 2, which is the A=B=1 state of the first cycle.
- R9: With `cfg_idx_half` = 1, `enc_idx` is high when the revolution count is below 2·`cfg_ppr`, and low otherwise.
- R10: With `cfg_enable` = 0, the outputs A, B and index are held low, no delta is captured, the backlog is discarded and `pos_o` holds its value.
- R11: `cfg_zero` = 1 clears `pos_o`, the revolution count and the backlog on the next clock, and holds A, B and index low.
- R12: A, B and index follow the position value and the controls with a latency of one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Enables motion and outputs |
| cfg_zero | input | 1 | Clears position, revolution count and backlog |
| cfg_idx_half | input | 1 | Index style: 0 short marker, 1 half-revolution level |
| cfg_period | input | PER_W (16) | Clocks per update period |
| cfg_modulus | input | ACC_W (30) | Accumulator wrap value |
| cfg_ppr | input | PPR_W (16) | Pulses per revolution |
| delta_in | input | DELTA_W (16) | Signed position delta |
| delta_ack | output | 1 | High in the cycle before `delta_in` is captured |
| enc_a | output | 1 | Quadrature channel A |
| enc_b | output | 1 | Quadrature channel B |
| enc_idx | output | 1 | Index marker |
| pos_o | output | ACC_W (30) | Position accumulator |

## Verification
The assertions assume that the configuration inputs are steady while the block runs. They also assume that `cfg_modulus` is a nonzero multiple of 4·`cfg_ppr`, and that the deltas the host feeds stay within the signed backlog range. The stimulus changes the configuration only while the backlog is empty or at update boundaries. It uses a modulus of 64 with 4 pulses per revolution and keeps each delta to a few tens of counts, so the backlog never comes close to its limit.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } dir_e;

  typedef struct packed {
    logic a;
    logic b;
  } quad_t;

  // Phase 0..3 of the position onto the Gray-coded channel pair.
  function automatic quad_t phase_to_quad(input logic [1:0] ph);
    quad_t q;
    q.a = ph[1] ^ ph[0];
    q.b = ph[1];
    return q;
  endfunction

endpackage

// File: rtl/qenc_tick_gen.sv
module qenc_tick_gen #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             tick
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] last_cnt;

  always_comb begin
    last_cnt = (period > PER_W'(1)) ? period - PER_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= last_cnt) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
      tick  <= 1'b0;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && run && period > PER_W'(1)) |=> !tick); // R2

  AST_TICK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick); // R10

endmodule

// File: rtl/qenc_backlog.sv
module qenc_backlog
  import qenc_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int PEND_W  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               tick,
  input  logic [DELTA_W-1:0] delta,
  output logic               step,
  output dir_e               dir
);

  localparam int EXT_W = PEND_W + 1;

  logic signed [PEND_W-1:0] pend_q;
  logic signed [EXT_W-1:0]  pend_ext;
  logic signed [EXT_W-1:0]  add_w;
  logic signed [EXT_W-1:0]  adj_w;
  logic signed [EXT_W-1:0]  sum_w;

  always_comb begin
    step     = run && (pend_q != '0);
    dir      = pend_q[PEND_W-1] ? DIR_DN : DIR_UP;
    pend_ext = {pend_q[PEND_W-1], pend_q};
    add_w    = tick ? {{(EXT_W-DELTA_W){delta[DELTA_W-1]}}, delta} : '0;
    if (!step)
      adj_w = '0;
    else if (dir == DIR_UP)
      adj_w = EXT_W'(1);
    else
      adj_w = {EXT_W{1'b1}};
    sum_w = pend_ext + add_w - adj_w;
  end

  always_ff @(posedge clk) begin
    if (rst || !run)
      pend_q <= '0;
    else
      pend_q <= sum_w[PEND_W-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    run |-> (sum_w[EXT_W-1] == sum_w[EXT_W-2])); // R6

  AST_DRAIN_UP: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && pend_q > 0) |=> (pend_q == $past(pend_q) - PEND_W'(1))); // R5

  AST_DRAIN_DN: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && pend_q < 0) |=> (pend_q == $past(pend_q) + PEND_W'(1))); // R5

  AST_DROP_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pend_q == '0)); // R10

endmodule

// File: rtl/qenc_position.sv
module qenc_position
  import qenc_pkg::*;
#(
  parameter int ACC_W = 30,
  parameter int PPR_W = 16,
  parameter int REV_W = PPR_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  dir_e             dir,
  input  logic [ACC_W-1:0] modulus,
  input  logic [PPR_W-1:0] ppr,
  output logic [ACC_W-1:0] pos_q,
  output logic [REV_W-1:0] rev_q
);

  logic [ACC_W-1:0] mod_last;
  logic [REV_W-1:0] rev_last;

  always_comb begin
    mod_last = modulus - ACC_W'(1);
    rev_last = {ppr, 2'b00} - REV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos_q <= '0;
      rev_q <= '0;
    end else if (step) begin
      if (dir == DIR_UP) begin
        pos_q <= (pos_q == mod_last) ? '0 : pos_q + ACC_W'(1);
        rev_q <= (rev_q == rev_last) ? '0 : rev_q + REV_W'(1);
      end else begin
        pos_q <= (pos_q == '0) ? mod_last : pos_q - ACC_W'(1);
        rev_q <= (rev_q == '0) ? rev_last : rev_q - REV_W'(1);
      end
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos_q < modulus); // R7

  AST_REV_RANGE: assert property (@(posedge clk) disable iff (rst)
    rev_q <= rev_last); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(pos_q)); // R10

  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pos_q == '0 && rev_q == '0)); // R11

endmodule

// File: rtl/qenc_drive.sv
module qenc_drive
  import qenc_pkg::*;
#(
  parameter int PPR_W = 16,
  parameter int REV_W = PPR_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             idx_half,
  input  logic [1:0]       phase,
  input  logic [REV_W-1:0] rev,
  input  logic [PPR_W-1:0] ppr,
  output logic             enc_a,
  output logic             enc_b,
  output logic             enc_idx
);

  quad_t            q_next;
  logic             idx_next;
  logic [REV_W-1:0] half_rev;
  logic             run_q;
  logic             half_q;

  always_comb begin
    q_next   = phase_to_quad(phase);
    half_rev = {1'b0, ppr, 1'b0};
    idx_next = idx_half ? (rev < half_rev) : (rev == REV_W'(2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_a   <= 1'b0;
      enc_b   <= 1'b0;
      enc_idx <= 1'b0;
      run_q   <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      enc_a   <= run && q_next.a;
      enc_b   <= run && q_next.b;
      enc_idx <= run && idx_next;
      run_q   <= run;
      half_q  <= idx_half;
    end
  end

  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> !((enc_a != $past(enc_a)) && (enc_b != $past(enc_b)))); // R5

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (!enc_a && !enc_b && !enc_idx)); // R10

  AST_SHORT_INDEX: assert property (@(posedge clk) disable iff (rst)
    (run_q && !half_q && enc_idx) |-> (enc_a && enc_b)); // R8

endmodule

// File: rtl/quad_enc_emu.sv
module quad_enc_emu
  import qenc_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int PEND_W  = 24,
  parameter int ACC_W   = 30,
  parameter int PPR_W   = 16,
  parameter int PER_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_enable,
  input  logic               cfg_zero,
  input  logic               cfg_idx_half,
  input  logic [PER_W-1:0]   cfg_period,
  input  logic [ACC_W-1:0]   cfg_modulus,
  input  logic [PPR_W-1:0]   cfg_ppr,
  input  logic [DELTA_W-1:0] delta_in,
  output logic               delta_ack,
  output logic               enc_a,
  output logic               enc_b,
  output logic               enc_idx,
  output logic [ACC_W-1:0]   pos_o
);

  localparam int REV_W = PPR_W + 2;

  logic             run;
  logic             tick;
  logic             step;
  dir_e             dir;
  logic [ACC_W-1:0] pos_q;
  logic [REV_W-1:0] rev_q;

  always_comb begin
    run = cfg_enable && !cfg_zero;
  end

  qenc_tick_gen #(
    .PER_W(PER_W)
  ) u_tick (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .period(cfg_period),
    .tick  (tick)
  );

  qenc_backlog #(
    .DELTA_W(DELTA_W),
    .PEND_W (PEND_W)
  ) u_backlog (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick),
    .delta(delta_in),
    .step (step),
    .dir  (dir)
  );

  qenc_position #(
    .ACC_W(ACC_W),
    .PPR_W(PPR_W),
    .REV_W(REV_W)
  ) u_pos (
    .clk    (clk),
    .rst    (rst),
    .clr    (cfg_zero),
    .step   (step),
    .dir    (dir),
    .modulus(cfg_modulus),
    .ppr    (cfg_ppr),
    .pos_q  (pos_q),
    .rev_q  (rev_q)
  );

  qenc_drive #(
    .PPR_W(PPR_W),
    .REV_W(REV_W)
  ) u_drive (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .idx_half(cfg_idx_half),
    .phase   (pos_q[1:0]),
    .rev     (rev_q),
    .ppr     (cfg_ppr),
    .enc_a   (enc_a),
    .enc_b   (enc_b),
    .enc_idx (enc_idx)
  );

  always_comb begin
    delta_ack = tick;
    pos_o     = pos_q;
  end

  AST_ACK_RESET: assert property (@(posedge clk)
    rst |=> (!delta_ack && pos_o == '0)); // R1

endmodule

// File: tb/quad_enc_emu_test.sv
module quad_enc_emu_test;

  localparam int CLK_PERIOD = 10;
  localparam int BM   = 64;
  localparam int BPPR = 4;
  localparam int EPR  = 4 * BPPR;
  localparam int WD_LIMIT = 100000;
  localparam int N_VEC = 8;
  localparam int VEC_D [N_VEC] = '{-3, 5, 12, -7, 20, -20, 1, -1};
  localparam int VEC_P [N_VEC] = '{1, 1, 3, 1, 2, 4, 1, 5};

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_enable;
  logic        cfg_zero;
  logic        cfg_idx_half;
  logic [15:0] cfg_period;
  logic [29:0] cfg_modulus;
  logic [15:0] cfg_ppr;
  logic [15:0] delta_in;
  logic        delta_ack;
  logic        enc_a;
  logic        enc_b;
  logic        enc_idx;
  logic [29:0] pos_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fwd_cnt = 0;
  int back_cnt = 0;
  int idx_hits = 0;
  int exp_pos = 0;

  bit prev_run = 1'b0;
  bit prev2_run = 1'b0;
  bit prev_zero = 1'b0;
  bit prev_half = 1'b0;
  int prev_pos = 0;
  int prev_st = 0;

  quad_enc_emu uut (
    .clk         (clk),
    .rst         (rst),
    .cfg_enable  (cfg_enable),
    .cfg_zero    (cfg_zero),
    .cfg_idx_half(cfg_idx_half),
    .cfg_period  (cfg_period),
    .cfg_modulus (cfg_modulus),
    .cfg_ppr     (cfg_ppr),
    .delta_in    (delta_in),
    .delta_ack   (delta_ack),
    .enc_a       (enc_a),
    .enc_b       (enc_b),
    .enc_idx     (enc_idx),
    .pos_o       (pos_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int st_of(input logic a, input logic b);
    if (!a && !b) return 0;
    if (a && !b) return 1;
    if (a && b) return 2;
    return 3;
  endfunction

  // Continuous monitor: outputs against the position one clock earlier.
  always @(negedge clk) begin
    int st;
    int rc;
    bit ea, eb, ei;
    int dp;
    st = st_of(enc_a, enc_b);
    if (prev_run) begin
      rc = prev_pos % EPR;
      ea = (prev_pos % 4 == 1) || (prev_pos % 4 == 2);
      eb = (prev_pos % 4 >= 2);
      ei = prev_half ? (rc < 2 * BPPR) : (rc == 2);
      chk(enc_a == ea && enc_b == eb, "R3 phase map (R12)", st, st_of(ea, eb));
      if (prev_half) chk(enc_idx == ei, "R9 half index", enc_idx, ei);
      else           chk(enc_idx == ei, "R8 short index", enc_idx, ei);
      if (prev2_run) begin
        if (st == (prev_st + 1) % 4) fwd_cnt++;
        else if (prev_st == (st + 1) % 4) back_cnt++;
        else chk(st == prev_st, "R5 single edge", st, prev_st);
      end
    end else if (!rst) begin
      chk(!enc_a && !enc_b && !enc_idx, "R10 idle outputs low", {enc_a, enc_b, enc_idx}, 0);
    end
    if (prev_run && !prev_zero) begin
      dp = (int'(pos_o) - prev_pos + BM) % BM;
      chk(dp == 0 || dp == 1 || dp == BM - 1, "R5 one count per clock", dp, 1);
    end
    if (enc_idx) idx_hits++;
    prev_st   = st;
    prev2_run = prev_run;
    prev_run  = !rst && cfg_enable && !cfg_zero;
    prev_zero = cfg_zero;
    prev_half = cfg_idx_half;
    prev_pos  = int'(pos_o);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic push(input int d);
    delta_in = 16'(d);
    while (!delta_ack) @(negedge clk);
    @(negedge clk);
    delta_in = '0;
  endtask

  task automatic send(input int d);
    push(d);
    repeat ((d < 0 ? -d : d) + 4) @(negedge clk);
    exp_pos = ((exp_pos + d) % BM + BM) % BM;
  endtask

  initial begin
    int gap;
    int snap;
    int d;
    rst = 1'b1;
    cfg_enable = 1'b0;
    cfg_zero = 1'b0;
    cfg_idx_half = 1'b0;
    cfg_period = 16'd1;
    cfg_modulus = 30'(BM);
    cfg_ppr = 16'(BPPR);
    delta_in = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!enc_a && !enc_b && !enc_idx && !delta_ack, "R1 outputs in reset",
        {enc_a, enc_b, enc_idx, delta_ack}, 0);
    chk(pos_o == 0, "R1 position in reset", int'(pos_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!enc_a && !enc_b && !enc_idx && pos_o == 0, "R1 after release", int'(pos_o), 0);
    cfg_enable = 1'b1;

    // R2: update spacing
    cfg_period = 16'd5;
    while (!delta_ack) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!delta_ack && gap < 50) begin
      @(negedge clk);
      gap++;
    end
    chk(gap == 5, "R2 ack spacing period 5", gap, 5);
    cfg_period = 16'd1;
    repeat (2) @(negedge clk);
    chk(delta_ack == 1'b1, "R2 ack every clock period 1", delta_ack, 1);
    @(negedge clk);
    chk(delta_ack == 1'b1, "R2 ack every clock period 1", delta_ack, 1);

    // Vector table: delta and update period
    for (int i = 0; i < N_VEC; i++) begin
      cfg_period = 16'(VEC_P[i]);
      fwd_cnt = 0;
      back_cnt = 0;
      send(VEC_D[i]);
      if (VEC_D[i] > 0) begin
        chk(fwd_cnt == VEC_D[i] && back_cnt == 0, "R3 forward edge count", fwd_cnt, VEC_D[i]);
        chk(int'(pos_o) == exp_pos, "R3 position after up", int'(pos_o), exp_pos);
      end else begin
        chk(back_cnt == -VEC_D[i] && fwd_cnt == 0, "R4 reverse edge count", back_cnt, -VEC_D[i]);
        chk(int'(pos_o) == exp_pos, "R4 position after down", int'(pos_o), exp_pos);
      end
      if (i == 0) chk(pos_o == 30'(BM - 3), "R7 wrap below zero", int'(pos_o), BM - 3);
      if (i == 1) chk(pos_o == 30'd2, "R7 wrap at modulus", int'(pos_o), 2);
    end

    // R6: second delta joins the backlog
    cfg_period = 16'd1;
    fwd_cnt = 0;
    back_cnt = 0;
    push(10);
    push(7);
    repeat (30) @(negedge clk);
    exp_pos = (exp_pos + 17) % BM;
    chk(fwd_cnt == 17, "R6 accumulated edges", fwd_cnt, 17);
    chk(int'(pos_o) == exp_pos, "R6 accumulated position", int'(pos_o), exp_pos);

    // R8: short index marker
    cfg_idx_half = 1'b0;
    idx_hits = 0;
    send(EPR);
    chk(idx_hits >= 1, "R8 index seen in a revolution", idx_hits, 1);
    send((2 - exp_pos % EPR + EPR) % EPR);
    chk(enc_idx && enc_a && enc_b, "R8 index at A=B=1", {enc_a, enc_b, enc_idx}, 7);
    send(1);
    chk(!enc_idx, "R8 index off one count later", enc_idx, 0);

    // R9: half-revolution level
    cfg_idx_half = 1'b1;
    send((3 - exp_pos % EPR + EPR) % EPR);
    chk(enc_idx == 1'b1, "R9 first half high", enc_idx, 1);
    send(7);
    chk(enc_idx == 1'b0, "R9 second half low", enc_idx, 0);
    send(6);
    chk(enc_idx == 1'b1, "R9 new revolution high", enc_idx, 1);

    // R10: disable mid-motion
    push(30);
    repeat (5) @(negedge clk);
    snap = int'(pos_o);
    cfg_enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(!enc_a && !enc_b && !enc_idx, "R10 outputs low when disabled",
        {enc_a, enc_b, enc_idx}, 0);
    delta_in = 16'd9;
    repeat (10) @(negedge clk);
    chk(!delta_ack, "R10 no capture when disabled", delta_ack, 0);
    chk(int'(pos_o) == snap, "R10 position held", int'(pos_o), snap);
    delta_in = '0;
    cfg_enable = 1'b1;
    repeat (40) @(negedge clk);
    chk(int'(pos_o) == snap, "R10 backlog discarded", int'(pos_o), snap);
    exp_pos = snap;

    // R11: zero control
    d = (exp_pos == 0) ? 5 : 0;
    send(d);
    cfg_zero = 1'b1;
    @(negedge clk);
    chk(pos_o == 0, "R11 position cleared", int'(pos_o), 0);
    @(negedge clk);
    chk(!enc_a && !enc_b && !enc_idx, "R11 outputs low", {enc_a, enc_b, enc_idx}, 0);
    cfg_zero = 1'b0;
    exp_pos = 0;
    cfg_idx_half = 1'b1;
    repeat (3) @(negedge clk);
    chk(enc_idx == 1'b1 && pos_o == 0, "R11 revolution count cleared", enc_idx, 1);
    send(6);
    chk(int'(pos_o) == 6, "R11 motion resumes from zero", int'(pos_o), 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule